// File: doc/BRIEF.md
# Interrupt Vector Dispatch Unit

This block turns a pending 8-bit vector number into a handler address. A request comes either from an external device or from a synchronous exception or software trap raised by the execution pipeline. External requests arrive asynchronously to the clock, so they pass through a synchroniser before the dispatcher sees them.

For an accepted vector, the unit forms the byte offset of the vector's descriptor. The offset is the vector times 8 in narrow mode and times 16 in wide mode. The unit checks that the descriptor's last byte fits inside the programmed table length, then adds the offset to the table base. It issues one read on a simple request/ready memory port and decodes the gate type held in the returned descriptor. An interrupt gate clears the maskable-interrupt enable flag as the handler address is released. A trap gate leaves that flag alone.

The handler address is presented with a one-cycle done pulse. A descriptor that lies outside the table, or that carries an unknown gate code, ends the dispatch with a fault flag instead of a handler address. The unit is busy from acceptance to done and takes nothing new in that time.

Top module: `vec_dispatch`

## Requirements
- R1: For an accepted vector V, the read address on `mem_addr` (valid while `mem_req` is high) is table base + (V << 3) when `mode_wide` is 0, and table base + (V << 4) when `mode_wide` is 1. `mode_wide` is sampled when the request is accepted.
- R2: A cycle with `tbl_wr` high loads both the table base and the table length from `tbl_base_in` and `tbl_len_in`. Every later dispatch uses the new pair.
- R3: If offset + descriptor size (8 or 16) exceeds the table length, no read is issued. The done pulse comes with `fault` high two cycles after acceptance, and `ie` is unchanged.
- R4: `mem_req` stays high with a stable `mem_addr` until a cycle in which `mem_ready` is high. The descriptor is captured in that cycle.
- R5: The descriptor holds the handler address in `mem_rdata[ADDR_W-1:0]` and the gate code in `mem_rdata[ADDR_W+1:ADDR_W]`. Gate code 01 (interrupt gate) drives `target` to the handler address with `fault` low, and `ie` reads 0 in the done cycle.
- R6: Gate code 10 (trap gate) drives `target` to the handler address with `fault` low and leaves `ie` unchanged. Gate codes 00 and 11 end with `fault` high and `ie` unchanged.
- R7: `done` is a single-cycle pulse, and `fault` is high only together with `done`. A synchronous request with a memory that answers after W wait cycles gives done 4+W cycles after it is driven.
- R8: `ext_req` is synchronised by two flops, and only its rising edge is a request. The request is accepted only while `ie` is 1, so done comes 6+W cycles after the rise. A rise while `ie` is 0 is ignored.
- R9: `exc_req` is accepted whatever the value of `ie`. If it arrives in the same cycle as a synchronised external rise, the exception is served and the external edge is dropped.
- R10: `busy` is high from the cycle after acceptance up to and including the done cycle. Requests arriving while busy are ignored.
- R11: After reset, `busy`, `done`, `fault`, `mem_req` and `ie` are 0. A pulse on `ie_set` sets `ie` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_wr | input | 1 | Load table base and length |
| tbl_base_in | input | ADDR_W | Table start address to load |
| tbl_len_in | input | LEN_W | Table length in bytes to load |
| mode_wide | input | 1 | 0: 8-byte descriptors, 1: 16-byte descriptors |
| ie_set | input | 1 | Set the maskable-interrupt enable flag |
| ext_req | input | 1 | Asynchronous external interrupt request |
| ext_vec | input | 8 | External vector, held stable while ext_req is high |
| exc_req | input | 1 | Synchronous exception / software trap request |
| exc_vec | input | 8 | Exception or trap vector |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | ADDR_W | Descriptor byte address |
| mem_ready | input | 1 | Read data valid |
| mem_rdata | input | ADDR_W+2 | Descriptor: gate code above handler address |
| busy | output | 1 | Dispatch in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Dispatch failed (limit or bad gate), with done |
| target | output | ADDR_W | Handler address, valid at done without fault |
| ie | output | 1 | Maskable-interrupt enable flag |

## Verification
A synchronous request driven in one cycle yields done exactly 4+W cycles later, where W is the memory wait. A limit fault yields done after 2 cycles. An external rise adds two synchroniser cycles, giving 6+W. The bench drives each stimulus at a falling edge and counts falling edges until `done` appears. It compares that count with the figure it has computed, and it reads the read address at the first falling edge where `mem_req` is high. It samples `target`, `fault` and `ie` at the done edge and `busy` one edge later, so every value is read in the cycle the register chain makes it due.

// File: rtl/vd_pkg.sv
package vd_pkg;
  localparam int unsigned VEC_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CALC   = 3'd1,
    ST_READ   = 3'd2,
    ST_DECODE = 3'd3,
    ST_DONE   = 3'd4
  } vd_state_e;

  typedef enum logic [1:0] {
    GATE_NONE = 2'b00,
    GATE_INTR = 2'b01,
    GATE_TRAP = 2'b10,
    GATE_RSVD = 2'b11
  } vd_gate_e;
endpackage

// File: rtl/vd_sync.sv
module vd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/vd_addr.sv
module vd_addr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned VEC_W  = 8
) (
  input  logic [VEC_W-1:0]  vec,
  input  logic              wide,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] addr,
  output logic              oob
);
  localparam int unsigned OFF_W = VEC_W + 5;
  localparam int unsigned CMP_W = (LEN_W > OFF_W) ? LEN_W : OFF_W;

  logic [OFF_W-1:0] off;
  logic [OFF_W-1:0] size;
  logic [OFF_W-1:0] off_end;
  logic [CMP_W-1:0] end_c;
  logic [CMP_W-1:0] len_c;

  always_comb begin
    off     = wide ? {1'b0, vec, 4'b0000} : {2'b00, vec, 3'b000};
    size    = wide ? OFF_W'(16) : OFF_W'(8);
    off_end = off + size;
    end_c   = CMP_W'(off_end);
    len_c   = CMP_W'(len);
    oob     = end_c > len_c;
    addr    = base + ADDR_W'(off);
  end
endmodule

// File: rtl/vd_decode.sv
module vd_decode
  import vd_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W+1:0] desc,
  output logic [ADDR_W-1:0] handler,
  output logic              clr_ie,
  output logic              bad
);
  vd_gate_e gate;

  always_comb begin
    handler = desc[ADDR_W-1:0];
    gate    = vd_gate_e'(desc[ADDR_W+1:ADDR_W]);
    clr_ie  = (gate == GATE_INTR);
    bad     = !((gate == GATE_INTR) || (gate == GATE_TRAP));
  end
endmodule

// File: rtl/vec_dispatch.sv
module vec_dispatch
  import vd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned LEN_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_wr,
  input  logic [ADDR_W-1:0] tbl_base_in,
  input  logic [LEN_W-1:0]  tbl_len_in,
  input  logic              mode_wide,
  input  logic              ie_set,
  input  logic              ext_req,
  input  logic [7:0]        ext_vec,
  input  logic              exc_req,
  input  logic [7:0]        exc_vec,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ready,
  input  logic [ADDR_W+1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [ADDR_W-1:0] target,
  output logic              ie
);
  localparam int unsigned DESC_W = ADDR_W + 2;

  vd_state_e         state_q, state_d;
  logic [ADDR_W-1:0] tbl_base_q;
  logic [LEN_W-1:0]  tbl_len_q;
  logic [VEC_W-1:0]  vec_q, vec_d;
  logic              wide_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DESC_W-1:0] desc_q;
  logic [ADDR_W-1:0] target_q;
  logic              fault_q, fault_d;
  logic              ie_q, ie_d;
  logic              ext_s, ext_last_q, ext_rise;
  logic              acc_exc, acc_ext, accept;
  logic              en_addr, en_desc, en_fault, en_target;
  logic [ADDR_W-1:0] calc_addr;
  logic              calc_oob;
  logic [ADDR_W-1:0] dec_handler;
  logic              dec_clr, dec_bad;

  vd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_req), .q(ext_s)
  );

  vd_addr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .VEC_W(VEC_W)) u_addr (
    .vec(vec_q), .wide(wide_q), .base(tbl_base_q), .len(tbl_len_q),
    .addr(calc_addr), .oob(calc_oob)
  );

  vd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .desc(desc_q), .handler(dec_handler), .clr_ie(dec_clr), .bad(dec_bad)
  );

  // Request arbitration: the synchronous source has priority.
  always_comb begin
    ext_rise = ext_s & ~ext_last_q;
    acc_exc  = (state_q == ST_IDLE) & exc_req;
    acc_ext  = (state_q == ST_IDLE) & ~exc_req & ext_rise & ie_q;
    accept   = acc_exc | acc_ext;
    vec_d    = acc_exc ? exc_vec : ext_vec;
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_CALC;
      ST_CALC:   state_d = calc_oob ? ST_DONE : ST_READ;
      ST_READ:   if (mem_ready) state_d = ST_DECODE;
      ST_DECODE: state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    en_addr   = (state_q == ST_CALC);
    en_desc   = (state_q == ST_READ) & mem_ready;
    en_fault  = (state_q == ST_CALC) | (state_q == ST_DECODE);
    fault_d   = (state_q == ST_CALC) ? calc_oob : dec_bad;
    en_target = (state_q == ST_DECODE) & ~dec_bad;
    ie_d      = ie_q;
    if (ie_set) ie_d = 1'b1;
    if ((state_q == ST_DECODE) && dec_clr) ie_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ext_last_q <= 1'b0;
      ie_q       <= 1'b0;
      fault_q    <= 1'b0;
      tbl_base_q <= '0;
      tbl_len_q  <= '0;
      vec_q      <= '0;
      wide_q     <= 1'b0;
      addr_q     <= '0;
      desc_q     <= '0;
      target_q   <= '0;
    end else begin
      state_q    <= state_d;
      ext_last_q <= ext_s;
      ie_q       <= ie_d;
      if (tbl_wr) begin
        tbl_base_q <= tbl_base_in;
        tbl_len_q  <= tbl_len_in;
      end
      if (accept) begin
        vec_q  <= vec_d;
        wide_q <= mode_wide;
      end
      if (en_addr)   addr_q   <= calc_addr;
      if (en_fault)  fault_q  <= fault_d;
      if (en_desc)   desc_q   <= mem_rdata;
      if (en_target) target_q <= dec_handler;
    end
  end

  assign mem_req  = (state_q == ST_READ);
  assign mem_addr = addr_q;
  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_DONE);
  assign fault    = done & fault_q;
  assign target   = target_q;
  assign ie       = ie_q;

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_read_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  assert_limit_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CALC && calc_oob) |=> (done && fault && !mem_req));

  assert_ie_clear_at_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ie) |-> (done && !fault));

  assert_exc_always_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && exc_req) |=> busy);

  assert_ext_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !exc_req && !ie) |=> !busy);
endmodule

// File: tb/vec_dispatch_tb.sv
module vec_dispatch_tb;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              tbl_wr;
  logic [ADDR_W-1:0] tbl_base_in;
  logic [LEN_W-1:0]  tbl_len_in;
  logic              mode_wide;
  logic              ie_set;
  logic              ext_req;
  logic [7:0]        ext_vec;
  logic              exc_req;
  logic [7:0]        exc_vec;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_ready;
  logic [ADDR_W+1:0] mem_rdata;
  logic              busy, done, fault, ie;
  logic [ADDR_W-1:0] target;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [1:0]        cur_gate;
  int                mem_wait;
  int                wcnt;
  logic [ADDR_W-1:0] m_base;
  logic [LEN_W-1:0]  m_len;
  bit                ie_m;

  always #4 clk = ~clk;

  vec_dispatch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tbl_wr(tbl_wr), .tbl_base_in(tbl_base_in),
    .tbl_len_in(tbl_len_in), .mode_wide(mode_wide), .ie_set(ie_set),
    .ext_req(ext_req), .ext_vec(ext_vec), .exc_req(exc_req), .exc_vec(exc_vec),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .fault(fault),
    .target(target), .ie(ie)
  );

  function automatic logic [ADDR_W-1:0] handler_of(input logic [ADDR_W-1:0] a);
    return a ^ 32'hC0DE_0000;
  endfunction

  // Memory model with a programmable number of wait cycles
  always @(posedge clk) begin
    if (!mem_req) wcnt <= 0;
    else if (!mem_ready) wcnt <= wcnt + 1;
  end
  assign mem_ready = mem_req && (wcnt == mem_wait);
  assign mem_rdata = {cur_gate, handler_of(mem_addr)};

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_ie();
    @(negedge clk); ie_set = 1'b1;
    @(negedge clk); ie_set = 1'b0;
    ie_m = 1'b1;
  endtask

  task automatic load_table(input logic [ADDR_W-1:0] b, input logic [LEN_W-1:0] l);
    @(negedge clk); tbl_wr = 1'b1; tbl_base_in = b; tbl_len_in = l;
    @(negedge clk); tbl_wr = 1'b0;
    m_base = b; m_len = l;
  endtask

  // src_ext: 0 = exception request, 1 = external request
  task automatic dispatch(input bit src_ext, input logic [7:0] v, input logic w,
                          input logic [1:0] g, input int wt, input bit poke);
    int sh, off, size, exp_lat, lat;
    bit oob, seen, bad, exp_ie;
    logic [ADDR_W-1:0] seen_addr, exp_addr;
    sh = w ? 4 : 3; size = w ? 16 : 8; off = int'(v) << sh;
    oob = (off + size) > int'(m_len);
    exp_addr = m_base + ADDR_W'(off);
    bad = !(g == 2'b01 || g == 2'b10);
    exp_lat = oob ? 2 : 4 + wt;
    if (src_ext) exp_lat += 2;
    exp_ie = (!oob && g == 2'b01) ? 1'b0 : ie_m;
    seen = 0; lat = 0; seen_addr = '0;
    @(negedge clk);
    mode_wide = w; cur_gate = g; mem_wait = wt;
    if (src_ext) begin ext_vec = v; ext_req = 1'b1; end
    else begin exc_vec = v; exc_req = 1'b1; end
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      if (mem_req && !seen) begin seen = 1; seen_addr = mem_addr; end
      if (done) begin lat = k; break; end
      if (k == 1) exc_req = 1'b0;
      if (poke && k == 2) begin exc_req = 1'b1; exc_vec = ~v; end
      if (poke && k == 3) exc_req = 1'b0;
    end
    exc_req = 1'b0;
    check(lat == exp_lat, "R7 done latency", lat, exp_lat);
    check(fault == (oob || bad), "R3/R6 fault flag", fault, oob || bad);
    check(ie == exp_ie, "R5/R6 ie after dispatch", ie, exp_ie);
    if (oob) check(!seen, "R3 no read on limit fault", seen, 0);
    else check(seen && seen_addr == exp_addr, "R1 descriptor address", seen_addr, exp_addr);
    if (!oob && !bad)
      check(target == handler_of(exp_addr), "R5 handler target", target, handler_of(exp_addr));
    ie_m = exp_ie;
    @(negedge clk);
    check(!busy && !done, "R10 busy clears after done pulse", busy, 0);
    if (src_ext) begin
      ext_req = 1'b0;
      repeat (4) @(negedge clk);
    end
    if (poke) begin
      bit any = 0;
      for (int k = 0; k < 10; k++) begin @(negedge clk); any |= busy; end
      check(!any, "R10 request while busy ignored", any, 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tbl_wr = 0; tbl_base_in = '0; tbl_len_in = '0; mode_wide = 0;
    ie_set = 0; ext_req = 0; ext_vec = '0; exc_req = 0; exc_vec = '0;
    cur_gate = 2'b01; mem_wait = 0; ie_m = 0; m_base = '0; m_len = '0;
    repeat (3) @(negedge clk);
    check({busy, done, fault, mem_req, ie} == 5'b0, "R11 reset outputs",
          {busy, done, fault, mem_req, ie}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, fault, mem_req, ie} == 5'b0, "R11 idle after reset",
          {busy, done, fault, mem_req, ie}, 0);
    set_ie();
    check(ie == 1'b1, "R11 ie_set sets flag", ie, 1);

    // R1/R3/R5/R6/R7 sweep: both modes, all vectors, mixed gates and waits
    load_table(32'h0010_0000, 16'h0800);
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 256; v++) begin
        logic [1:0] g;
        if (v % 7 == 3) g = 2'b11;
        else if (v % 11 == 5) g = 2'b00;
        else g = v[0] ? 2'b10 : 2'b01;
        if (v[1]) set_ie();
        dispatch(1'b0, 8'(v), m[0], g, v % 3, 1'b0);
      end
    end

    // R2: reload table, boundary at vector 31 / 32 in narrow mode
    load_table(32'h4000_0000, 16'h0100);
    dispatch(1'b0, 8'd31, 1'b0, 2'b10, 0, 1'b0);
    dispatch(1'b0, 8'd32, 1'b0, 2'b10, 0, 1'b0);
    dispatch(1'b0, 8'd15, 1'b1, 2'b10, 1, 1'b0);
    dispatch(1'b0, 8'd16, 1'b1, 2'b10, 1, 1'b0);

    // R9: exception accepted while ie is clear
    load_table(32'h0020_0000, 16'h1000);
    dispatch(1'b0, 8'd40, 1'b0, 2'b01, 0, 1'b0);
    check(ie == 1'b0, "R9 ie clear before exception", ie, 0);
    dispatch(1'b0, 8'd7, 1'b1, 2'b10, 2, 1'b0);

    // R8: masked external request is ignored
    begin
      bit any = 0;
      @(negedge clk); ext_vec = 8'd50; ext_req = 1'b1;
      for (int k = 0; k < 12; k++) begin @(negedge clk); any |= busy; end
      check(!any, "R8 external ignored while ie clear", any, 0);
      ext_req = 1'b0;
      repeat (4) @(negedge clk);
    end

    // R8: external accepted with ie set, several vectors and waits
    for (int v = 32; v < 256; v += 37) begin
      set_ie();
      dispatch(1'b1, 8'(v), v[0], v[1] ? 2'b10 : 2'b01, v % 4, 1'b0);
    end

    // R10: request while busy is dropped
    dispatch(1'b0, 8'd100, 1'b0, 2'b10, 5, 1'b1);

    // R9: exception wins over a simultaneous external edge
    begin
      bit any = 0;
      int lat = 0;
      logic [ADDR_W-1:0] a_seen = '0;
      set_ie();
      mem_wait = 0; cur_gate = 2'b10; mode_wide = 1'b0;
      @(negedge clk); ext_vec = 8'd64; ext_req = 1'b1;
      @(negedge clk);
      @(negedge clk); exc_vec = 8'd33; exc_req = 1'b1;
      for (int k = 1; k <= 20; k++) begin
        @(negedge clk);
        if (k == 1) exc_req = 1'b0;
        if (mem_req) a_seen = mem_addr;
        if (done) begin lat = k; break; end
      end
      check(lat == 4, "R9 exception latency under contention", lat, 4);
      check(a_seen == m_base + 32'd264, "R9 exception vector served", a_seen, m_base + 32'd264);
      ext_req = 1'b0;
      for (int k = 0; k < 12; k++) begin @(negedge clk); any |= busy; end
      check(!any, "R9 external edge dropped", any, 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule